// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked requester inside the chip read and write an external asynchronous static RAM of 65,536 four-bit words. The requester sees a request/ready handshake. It presents an address, a write flag and write data while `ready` is high. Read data comes back with a one-clock valid strobe. On the memory side the block drives an active-low chip select, an active-low write enable and the address bus. It drives a shared four-bit data bus through a separate output-enable line. All memory timing comes from a clock-period parameter and a set of minimum-time parameters in nanoseconds. Each minimum time is turned into a whole number of clocks.

The sequencing is done by one state machine, `st_q`, with five states. Its phase lengths are timed by a single down-counter.
- `ST_IDLE`: memory deselected, `ready` high. On an accepted request (`req` and `ready` both high) the machine goes to `ST_READ` when the write flag is clear, or to `ST_WR_SETUP` when it is set.
- `ST_READ`: chip select low, write enable high, for the read-cycle count. On expiry it samples the bus, pulses `rdata_valid` and goes to `ST_RECOVER`.
- `ST_WR_SETUP`: chip select and write enable low together, and the data drivers are off. This lets the memory release the bus. On expiry it goes to `ST_WR_PULSE`.
- `ST_WR_PULSE`: both strobes stay low and the data drivers are on. On expiry both strobes rise together and the machine goes to `ST_RECOVER`.
- `ST_RECOVER`: memory deselected for the recovery count. The data drivers stay on if the cycle was a write. On expiry it goes to `ST_IDLE`.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and on leaving it, `mem_cs_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `ready` is 1 and `rdata_valid` is 0.
- R2: `ready` is 1 exactly when no cycle is in progress. A request is taken only on a clock edge where `req` and `ready` are both 1. `req` asserted while `ready` is 0 has no effect on any cycle or on the memory contents.
- R3: A read holds `mem_cs_n`=0 and `mem_we_n`=1 with the captured address for RC clocks. `rdata_valid` is then 1 for exactly one clock, with `rdata` equal to the word stored at that address. `rdata_valid` rises RC clocks after the accepting edge.
- R4: In a write, `mem_cs_n` and `mem_we_n` fall on the same edge. `mem_dq_oe` stays 0 for WZ clocks after write enable falls, so that the controller never drives while the memory may still be driving.
- R5: Write enable is low for at least max(WP, AW) clocks, and chip select is low for at least AW clocks. The write data is driven and stable for at least DW clocks before the end of the write. Both strobes rise on the same edge, and the word written is the data captured with the request.
- R6: After every read or write, both strobes stay high for at least WR clocks before the next cycle starts. The write data stays driven through recovery (zero hold). `mem_dq_oe` is 0 whenever `ready` is 1.
- R7: Each timing count is max(1, ceil(t_ns / CLK_PERIOD_NS)). With the defaults (10 ns clock; 45, 30, 40, 20, 3 and 15 ns) RC=5, WP=3, AW=4, DW=2, WR=1 and WZ=2. The write pulse phase is max(DW, WP-WZ, AW-WZ, 1)=2 clocks, and a write returns `ready` WZ+pulse+WR=5 clocks after acceptance.
- R8: While idle the memory is deselected (`mem_cs_n`=1, `mem_we_n`=1).
- R9: `mem_dq_oe` is never 1 while `mem_cs_n`=0 and `mem_we_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request a memory cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Controller idle, request will be taken |
| rdata | output | 4 | Read data |
| rdata_valid | output | 1 | One-clock strobe marking `rdata` |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 16 | Memory address bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_o | output | 4 | Data driven toward the memory |
| mem_dq_i | input | 4 | Data received from the shared bus |

## Verification
The hardest situation to reach from the ports is a memory that is still driving the bus while the controller turns its own drivers on. Another is a read sampled before the access time. Neither shows up at the user-side ports if the memory happens to return stale but plausible data. The bench therefore uses a nanosecond-resolution memory model. It returns inverted data until the access time has passed since the last chip-select or address change. It also treats the bus as memory-driven for the full release window after write enable falls. Write strobes, data windows and recovery gaps are measured in real time at every write end. Requests held high through busy periods, and back-to-back alternating reads and writes, put the shortest legal gaps between cycles.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_RECOVER
    } state_t;

    // Whole clocks covering a minimum time, never less than one.
    function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                              input int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Write pulse phase: data window, rest of write pulse, rest of chip-select window.
    function automatic int unsigned pulse_cyc(input int unsigned dw_c,
                                              input int unsigned wp_c,
                                              input int unsigned aw_c,
                                              input int unsigned wz_c);
        int unsigned p;
        p = dw_c;
        if (wp_c > wz_c) p = max_u(p, wp_c - wz_c);
        if (aw_c > wz_c) p = max_u(p, aw_c - wz_c);
        if (p == 0) p = 1;
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            st_d,
    input  logic              take,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic              cs_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o
);
    logic cs_n_d;
    logic we_n_d;
    logic oe_d;

    // Pin levels follow the state being entered, so they change with the state register.
    always_comb begin
        cs_n_d = 1'b1;
        we_n_d = 1'b1;
        oe_d   = 1'b0;
        unique case (st_d)
            ST_IDLE: begin
            end
            ST_READ: begin
                cs_n_d = 1'b0;
            end
            ST_WR_SETUP: begin
                cs_n_d = 1'b0;
                we_n_d = 1'b0;
            end
            ST_WR_PULSE: begin
                cs_n_d = 1'b0;
                we_n_d = 1'b0;
                oe_d   = 1'b1;
            end
            ST_RECOVER: begin
                oe_d   = dq_oe;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= cs_n_d;
            we_n  <= we_n_d;
            dq_oe <= oe_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            dq_o <= '0;
        end else if (take) begin
            addr <= addr_in;
            dq_o <= wdata_in;
        end
    end

endmodule

// File: rtl/sram_ctl_rdcap.sv
`timescale 1ns/1ps
module sram_ctl_rdcap #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= sample;
            if (sample) rdata <= dq_i;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned DATA_W        = 4,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 45,
    parameter int unsigned T_WP_NS       = 30,
    parameter int unsigned T_AW_NS       = 40,
    parameter int unsigned T_DW_NS       = 20,
    parameter int unsigned T_WR_NS       = 3,
    parameter int unsigned T_WZ_NS       = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] mem_dq_o,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int unsigned RC_C  = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned WP_C  = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned AW_C  = ns_to_cyc(T_AW_NS, CLK_PERIOD_NS);
    localparam int unsigned DW_C  = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned WR_C  = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int unsigned WZ_C  = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);
    localparam int unsigned PUL_C = pulse_cyc(DW_C, WP_C, AW_C, WZ_C);
    localparam int unsigned MAX_C = max_u(max_u(RC_C, PUL_C), max_u(WZ_C, WR_C));
    localparam int unsigned CW    = $clog2(MAX_C + 1);

    state_t        st_q;
    state_t        st_d;
    logic          tm_load;
    logic [CW-1:0] tm_val;
    logic          tm_done;
    logic          take;
    logic          sample;

    assign ready = (st_q == ST_IDLE);
    assign take  = req && ready;

    // Next-state and phase timing
    always_comb begin
        st_d    = st_q;
        tm_load = 1'b0;
        tm_val  = '0;
        sample  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    tm_load = 1'b1;
                    if (req_we) begin
                        st_d   = ST_WR_SETUP;
                        tm_val = CW'(WZ_C - 1);
                    end else begin
                        st_d   = ST_READ;
                        tm_val = CW'(RC_C - 1);
                    end
                end
            end
            ST_READ: begin
                if (tm_done) begin
                    st_d    = ST_RECOVER;
                    tm_load = 1'b1;
                    tm_val  = CW'(WR_C - 1);
                    sample  = 1'b1;
                end
            end
            ST_WR_SETUP: begin
                if (tm_done) begin
                    st_d    = ST_WR_PULSE;
                    tm_load = 1'b1;
                    tm_val  = CW'(PUL_C - 1);
                end
            end
            ST_WR_PULSE: begin
                if (tm_done) begin
                    st_d    = ST_RECOVER;
                    tm_load = 1'b1;
                    tm_val  = CW'(WR_C - 1);
                end
            end
            ST_RECOVER: begin
                if (tm_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_done)
    );

    // Output register for the memory pins
    sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_d     (st_d),
        .take     (take),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe),
        .addr     (mem_addr),
        .dq_o     (mem_dq_o)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .dq_i   (mem_dq_i),
        .rdata  (rdata),
        .rvalid (rdata_valid)
    );

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) (req && ready) |=> !ready); // R2
    AST_RVALID_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) rdata_valid |=> !rdata_valid); // R3
    AST_OE_AFTER_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n))); // R4
    AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> $rose(mem_cs_n)); // R5
    AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> !mem_cs_n); // R5
    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_cs_n) |=> mem_cs_n); // R6
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) ready |-> !mem_dq_oe); // R6
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) ready |-> (mem_cs_n && mem_we_n)); // R8
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !(mem_dq_oe && !mem_cs_n && mem_we_n)); // R9

endmodule

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
    localparam int AW_B = 16;
    localparam int DW_B = 4;
    localparam int CLKP = 10;
    localparam int T_RC = 45, T_AA = 45, T_WP = 30, T_AWE = 40, T_DWE = 20, T_WR = 3, T_WZ = 15;

    function automatic int cyc(input int t);
        int c;
        c = (t + CLKP - 1) / CLKP;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int RC_N  = cyc(T_RC);
    localparam int WZ_N  = cyc(T_WZ);
    localparam int WR_N  = cyc(T_WR);
    localparam int PUL_N = 2;                       // R7: max(DW, WP-WZ, AW-WZ, 1) at defaults
    localparam int RD_TOT = RC_N + WR_N;
    localparam int WR_TOT = WZ_N + PUL_N + WR_N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, req_we = 1'b0;
    logic [AW_B-1:0] req_addr = '0;
    logic [DW_B-1:0] req_wdata = '0;
    logic ready, rdata_valid, mem_cs_n, mem_we_n, mem_dq_oe;
    logic [DW_B-1:0] rdata, mem_dq_o;
    logic [DW_B-1:0] mem_dq_i = '0;
    logic [AW_B-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .mem_dq_oe(mem_dq_oe), .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] dflt(input int unsigned a);
        return 4'(a ^ (a >> 5) ^ 32'h9);
    endfunction

    // ---------------- memory model with real-time checks ----------------
    logic [3:0] mdl_mem [int unsigned];
    real t_cs_fall = -1000.0, t_we_fall = -1000.0, t_addr = -1000.0;
    real t_data = -1000.0, t_wend = -1000.0, t_acc = -1000.0;
    logic pcs = 1'b1, pwe = 1'b1, poe = 1'b0;
    logic [AW_B-1:0] paddr = '0;
    logic [DW_B-1:0] pdq = '0;

    initial begin
        real now;
        logic [3:0] word;
        #0.5;
        forever begin
            now = $realtime;
            if (rst_n) begin
                if ((pcs && !mem_cs_n) || (pwe && !mem_we_n))
                    chk(now - t_wend >= T_WR, "R6", "recovery ns before strobe", int'(now - t_wend), T_WR);
                if (pcs && !mem_cs_n) t_cs_fall = now;
                if (pwe && !mem_we_n) t_we_fall = now;
                if (mem_addr != paddr) t_addr = now;
                if (mem_dq_oe && (!poe || mem_dq_o != pdq)) t_data = now;
                if (!pcs && !pwe && (mem_cs_n || mem_we_n)) begin
                    chk(mem_cs_n && mem_we_n, "R5", "strobes rise together", int'(mem_cs_n), 1);
                    chk(now - t_we_fall >= T_WP, "R5", "write pulse ns", int'(now - t_we_fall), T_WP);
                    chk(now - t_cs_fall >= T_AWE, "R5", "cs to end of write ns", int'(now - t_cs_fall), T_AWE);
                    chk(now - t_addr >= T_AWE, "R5", "address to end of write ns", int'(now - t_addr), T_AWE);
                    chk(poe && (now - t_data >= T_DWE), "R5", "data before end of write ns", int'(now - t_data), T_DWE);
                    mdl_mem[int'(paddr)] = pdq;
                    t_wend = now;
                end
                if (!pcs && (mem_cs_n || mem_we_n) && pwe && mem_cs_n) t_wend = now;
                if (mem_dq_oe && !mem_cs_n && (mem_we_n || (now - t_we_fall < T_WZ)))
                    chk(1'b0, "R4", "bus contention with memory output", 1, 0);
                if (!mem_cs_n && mem_we_n && (pcs || !pwe || mem_addr != paddr)) t_acc = now;
            end
            if (!mem_cs_n && mem_we_n) begin
                word = mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : dflt(mem_addr);
                mem_dq_i = (now - t_acc >= T_AA) ? word : ~word;
            end else begin
                mem_dq_i = '0;
            end
            pcs = mem_cs_n; pwe = mem_we_n; poe = mem_dq_oe; paddr = mem_addr; pdq = mem_dq_o;
            #1;
        end
    end

    // ---------------- cycle reference model of the user side ----------------
    logic [3:0] ref_mem [int unsigned];
    int busy = 0;
    int lat = 0;
    bit cur_rd = 1'b0;
    bit exp_rv = 1'b0;
    logic [AW_B-1:0] cur_addr = '0;
    logic [3:0] exp_rd = '0;
    bit prev_ready = 1'b1;

    always @(posedge clk) begin
        exp_rv = 1'b0;
        if (!rst_n) begin
            busy = 0;
        end else begin
            lat++;
            if (busy > 0) begin
                busy--;
                if (cur_rd && busy == WR_N) begin
                    exp_rv = 1'b1;
                    exp_rd = ref_mem.exists(int'(cur_addr)) ? ref_mem[int'(cur_addr)] : dflt(cur_addr);
                end
            end else if (req) begin
                cur_rd = !req_we;
                cur_addr = req_addr;
                busy = req_we ? WR_TOT : RD_TOT;
                lat = 0;
                if (req_we) ref_mem[int'(req_addr)] = req_wdata;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(ready == (busy == 0), "R2", "ready vs reference", int'(ready), int'(busy == 0));
            chk(rdata_valid == exp_rv, "R3", "rdata_valid vs reference", int'(rdata_valid), int'(exp_rv));
            if (exp_rv) begin
                chk(rdata == exp_rd, "R3", "read data", int'(rdata), int'(exp_rd));
                chk(lat == RC_N, "R7", "read latency clocks", lat, RC_N);
            end
            if (busy == 0) begin
                chk(mem_cs_n && mem_we_n, "R8", "deselected when idle", int'({mem_cs_n, mem_we_n}), 3);
                chk(!mem_dq_oe, "R6", "drivers off when idle", int'(mem_dq_oe), 0);
                if (!prev_ready && !cur_rd)
                    chk(lat == WR_TOT, "R7", "write turnaround clocks", lat, WR_TOT);
            end
            if (!mem_cs_n && mem_we_n)
                chk(!mem_dq_oe, "R9", "no drive during read", int'(mem_dq_oe), 0);
            prev_ready = (busy == 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit we, input logic [AW_B-1:0] a, input logic [DW_B-1:0] d);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        req = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * CLKP);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        // R1: reset levels
        chk(mem_cs_n && mem_we_n, "R1", "strobes in reset", int'({mem_cs_n, mem_we_n}), 3);
        chk(!mem_dq_oe && ready && !rdata_valid, "R1", "oe/ready/valid in reset",
            int'({mem_dq_oe, ready, rdata_valid}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe && ready, "R1", "levels after reset", int'({mem_cs_n, mem_dq_oe, ready}), 5);

        // R3: reads of untouched words at both ends
        op(1'b0, 16'h0000, 4'h0);
        op(1'b0, 16'hFFFF, 4'h0);
        settle();
        // R5: writes then read back
        op(1'b1, 16'h0005, 4'hA);
        settle();
        op(1'b0, 16'h0005, 4'h0);
        op(1'b1, 16'hFFFF, 4'h3);
        op(1'b0, 16'hFFFF, 4'h0);
        settle();
        // R6: back-to-back write/write/read/read with no idle gap
        op(1'b1, 16'h0100, 4'h1);
        op(1'b1, 16'h0101, 4'hE);
        op(1'b0, 16'h0100, 4'h0);
        op(1'b0, 16'h0101, 4'h0);
        op(1'b1, 16'h0100, 4'h7);
        op(1'b0, 16'h0100, 4'h0);
        settle();
        // R2: requests while busy are ignored
        op(1'b1, 16'h0007, 4'h5);
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0007; req_wdata = 4'hC;
        @(negedge clk);
        req_addr = 16'h0008; req_wdata = 4'h6;
        @(negedge clk);
        req = 1'b0;
        while (!ready) @(negedge clk);
        @(negedge clk);
        op(1'b0, 16'h0007, 4'h0);
        op(1'b0, 16'h0008, 4'h0);
        settle();
        // mixed traffic over a small address window
        lf = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], {12'h0F0, lf[7:4]}, lf[11:8]);
            if (lf[1] && lf[2]) settle();
        end
        settle();
        summary();
    end

endmodule